// File: doc/BRIEF.md
# Element-Width Polymorphic Register File

This block holds a file of 64-bit integer registers. Through one read port and one write port it can treat the file as packed elements of 8, 16, 32 or 64 bits. The whole file is handled as one flat little-endian byte array. Each port names a base register, an element width code, an element index and a vector/scalar flag.

A vector access addresses element k counted from the named register. A large index reaches past that register into the ones after it. A scalar access always uses element zero. A scalar write stores the value, masked to the element width, into all 64 bits of the named register, so the upper bits of that register are cleared. A vector write changes only the byte lanes of its own element.

A read result is the element zero-extended to 64 bits. Any access that lands past the last register is dropped on write and reads back as zero. There is no data stream here, so neither port has a valid/ready handshake and there is no back-pressure. The read is a combinational lookup. The write is a single-cycle command qualified by its enable.

Top module: `ewrf_top`

## Requirements
- R1: After reset every register reads as zero.
- R2: The width code selects the element size: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. A vector element k of size n bytes, based at register r, occupies flat bytes r*8 + k*n to r*8 + k*n + n - 1. Register q holds bytes q*8 (bit 0..7) through q*8+7 (bit 56..63).
- R3: When the vector flag is low, the element index is ignored and treated as zero, on both reads and writes.
- R4: A read returns the element in the low bits of the 64-bit result, and every bit above the element size is zero.
- R5: A scalar write stores the data masked to the element size into the named register, and that register's remaining upper bits become zero.
- R6: A vector write changes only the n bytes of its element. Every other byte of the file keeps its value.
- R7: A vector element whose byte position k*n is 8 or more lands in register r + (r*8 + k*n)/8 - r, that is, in a following register.
- R8: A vector access whose first byte lies at or beyond the end of the file writes nothing and reads as zero.
- R9: A write takes effect at the rising clock edge only while the write enable is high. With the enable low, no byte changes.
- R10: A read of the bytes being written in the same cycle returns the contents from before that write (no bypass).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset, clears all registers |
| rd_reg | input | 5 | Read base register number |
| rd_width | input | 2 | Read element width code |
| rd_off | input | 8 | Read element index (vector only) |
| rd_vec | input | 1 | Read is a vector access when high |
| rd_data | output | 64 | Zero-extended read element |
| wr_en | input | 1 | Write enable |
| wr_reg | input | 5 | Write base register number |
| wr_width | input | 2 | Write element width code |
| wr_off | input | 8 | Write element index (vector only) |
| wr_vec | input | 1 | Write is a vector access when high |
| wr_data | input | 64 | Write value (masked to element size) |

## Verification
A read result is due in the same cycle its port inputs change, so the bench drives the read inputs after a falling edge and samples them one nanosecond later, before the next rising edge. A write becomes visible only after the next rising edge. Each write is therefore applied across one rising edge, and its effect is read back in the following low phase. For the same-cycle case, the read is sampled before that edge and again after it. Expected values come from a byte-array model in the bench, which is updated only after the edge that commits the write.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_t;

  localparam int XLEN  = 64;
  localparam int LANES = XLEN / 8;

  function automatic logic [XLEN-1:0] ew_mask(input logic [1:0] w);
    case (w)
      2'd0:    ew_mask = 64'h0000_0000_0000_00FF;
      2'd1:    ew_mask = 64'h0000_0000_0000_FFFF;
      2'd2:    ew_mask = 64'h0000_0000_FFFF_FFFF;
      default: ew_mask = '1;
    endcase
  endfunction

  function automatic logic [LANES-1:0] ew_lanes(input logic [1:0] w);
    case (w)
      2'd0:    ew_lanes = 8'h01;
      2'd1:    ew_lanes = 8'h03;
      2'd2:    ew_lanes = 8'h0F;
      default: ew_lanes = 8'hFF;
    endcase
  endfunction

  function automatic int ew_bytes(input logic [1:0] w);
    ew_bytes = 1 << w;
  endfunction

endpackage

// File: rtl/ewrf_locate.sv
module ewrf_locate #(
  parameter int NREGS = 32,
  parameter int REG_W = 5,
  parameter int OFF_W = 8
) (
  input  logic [REG_W-1:0] reg_i,
  input  logic [1:0]       width_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             vec_i,
  output logic [REG_W-1:0] row_o,
  output logic [2:0]       lane_o,
  output logic             hit_o
);
  localparam int AW = ((REG_W > OFF_W) ? REG_W : OFF_W) + 4;

  logic [OFF_W-1:0] eff_off;
  logic [AW-1:0]    ofs_bytes;
  logic [AW-1:0]    addr;
  logic [AW-4:0]    row_full;

  always_comb begin
    eff_off   = vec_i ? off_i : '0;
    ofs_bytes = AW'(eff_off) << width_i;
    addr      = (AW'(reg_i) << 3) + ofs_bytes;
    row_full  = addr[AW-1:3];
    lane_o    = addr[2:0];
    row_o     = row_full[REG_W-1:0];
    hit_o     = int'(row_full) < NREGS;
  end
endmodule

// File: rtl/ewrf_extract.sv
module ewrf_extract (
  input  logic [63:0] row_i,
  input  logic [2:0]  lane_i,
  input  logic [1:0]  width_i,
  input  logic        hit_i,
  output logic [63:0] data_o
);
  import ewrf_pkg::*;

  always_comb begin
    if (hit_i) data_o = (row_i >> {lane_i, 3'b000}) & ew_mask(width_i);
    else       data_o = '0;
  end
endmodule

// File: rtl/ewrf_merge.sv
module ewrf_merge (
  input  logic        en_i,
  input  logic        hit_i,
  input  logic        vec_i,
  input  logic [2:0]  lane_i,
  input  logic [1:0]  width_i,
  input  logic [63:0] data_i,
  output logic [7:0]  be_o,
  output logic [63:0] wd_o
);
  import ewrf_pkg::*;

  always_comb begin
    wd_o = (data_i & ew_mask(width_i)) << {lane_i, 3'b000};
    if (!(en_i && hit_i)) be_o = '0;
    else if (vec_i)       be_o = ew_lanes(width_i) << lane_i;
    else                  be_o = 8'hFF;
  end
endmodule

// File: rtl/ewrf_top.sv
module ewrf_top #(
  parameter int NREGS = 32,
  parameter int REG_W = 5,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] rd_reg,
  input  logic [1:0]       rd_width,
  input  logic [OFF_W-1:0] rd_off,
  input  logic             rd_vec,
  output logic [63:0]      rd_data,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_reg,
  input  logic [1:0]       wr_width,
  input  logic [OFF_W-1:0] wr_off,
  input  logic             wr_vec,
  input  logic [63:0]      wr_data
);
  import ewrf_pkg::*;

  logic [63:0]      mem_q [NREGS];
  logic [REG_W-1:0] rd_row, wr_row;
  logic [2:0]       rd_lane, wr_lane;
  logic             rd_hit, wr_hit;
  logic [7:0]       wr_be;
  logic [63:0]      wr_wd;

  ewrf_locate #(.NREGS(NREGS), .REG_W(REG_W), .OFF_W(OFF_W)) u_rloc (
    .reg_i(rd_reg), .width_i(rd_width), .off_i(rd_off), .vec_i(rd_vec),
    .row_o(rd_row), .lane_o(rd_lane), .hit_o(rd_hit)
  );

  ewrf_locate #(.NREGS(NREGS), .REG_W(REG_W), .OFF_W(OFF_W)) u_wloc (
    .reg_i(wr_reg), .width_i(wr_width), .off_i(wr_off), .vec_i(wr_vec),
    .row_o(wr_row), .lane_o(wr_lane), .hit_o(wr_hit)
  );

  ewrf_extract u_ext (
    .row_i(mem_q[rd_row]), .lane_i(rd_lane), .width_i(rd_width),
    .hit_i(rd_hit), .data_o(rd_data)
  );

  ewrf_merge u_mrg (
    .en_i(wr_en), .hit_i(wr_hit), .vec_i(wr_vec), .lane_i(wr_lane),
    .width_i(wr_width), .data_i(wr_data), .be_o(wr_be), .wd_o(wr_wd)
  );

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem_q[gi] <= '0;
      end else if (wr_row == REG_W'(gi)) begin
        for (int b = 0; b < 8; b++) begin
          if (wr_be[b]) mem_q[gi][b*8 +: 8] <= wr_wd[b*8 +: 8];
        end
      end
    end
  end

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_width != 2'd3) |-> ((rd_data & ~ew_mask(rd_width)) == 64'd0)); // R4

  AST_RD_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_data == 64'd0)); // R8

  AST_WR_OOR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |-> (wr_be == 8'd0)); // R8

  AST_WR_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (wr_be == 8'd0)); // R9

  AST_VEC_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_vec && wr_hit) |-> ($countones(wr_be) == ew_bytes(wr_width))); // R6

  AST_SCALAR_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_vec && wr_hit) |=>
      (mem_q[$past(wr_reg)] == ($past(wr_data) & ew_mask($past(wr_width))))); // R5
endmodule

// File: tb/sim_ewrf_top.sv
`timescale 1ns/100ps
module sim_ewrf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_reg = '0;
  logic [1:0]  rd_width = '0;
  logic [7:0]  rd_off = '0;
  logic        rd_vec = 1'b0;
  logic [63:0] rd_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_reg = '0;
  logic [1:0]  wr_width = '0;
  logic [7:0]  wr_off = '0;
  logic        wr_vec = 1'b0;
  logic [63:0] wr_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] refb [256];

  always #2.5 clk = ~clk;

  ewrf_top u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_reg(rd_reg), .rd_width(rd_width), .rd_off(rd_off), .rd_vec(rd_vec),
    .rd_data(rd_data),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_width(wr_width), .wr_off(wr_off),
    .wr_vec(wr_vec), .wr_data(wr_data)
  );

  function automatic int first_byte(int r, int w, int k, bit v);
    return r * 8 + (v ? k : 0) * (1 << w);
  endfunction

  function automatic logic [63:0] model_rd(int r, int w, int k, bit v);
    logic [63:0] res = '0;
    int a = first_byte(r, w, k, v);
    if (a >= 256) return '0;
    for (int j = 0; j < (1 << w); j++) res[j*8 +: 8] = refb[a + j];
    return res;
  endfunction

  task automatic model_wr(int r, int w, int k, bit v, logic [63:0] d);
    int a = first_byte(r, w, k, v);
    logic [63:0] m = (w == 3) ? '1 : ((64'd1 << (8 << w)) - 64'd1);
    logic [63:0] md = d & m;
    if (!v) begin
      for (int j = 0; j < 8; j++) refb[r*8 + j] = md[j*8 +: 8];
    end else if (a < 256) begin
      for (int j = 0; j < (1 << w); j++) refb[a + j] = md[j*8 +: 8];
    end
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_rd(int r, int w, int k, bit v, string tag);
    @(negedge clk);
    rd_reg = 5'(r); rd_width = 2'(w); rd_off = 8'(k); rd_vec = v;
    #1;
    check(tag, rd_data, model_rd(r, w, k, v));
  endtask

  task automatic do_wr(int r, int w, int k, bit v, logic [63:0] d);
    @(negedge clk);
    wr_reg = 5'(r); wr_width = 2'(w); wr_off = 8'(k); wr_vec = v;
    wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
    model_wr(r, w, k, v, d);
  endtask

  function automatic logic [63:0] pat(int i);
    return (64'(i) + 64'd1) * 64'h9E37_79B9_7F4A_7C15 ^ 64'hA5A5_0F0F_3C3C_C3C3;
  endfunction

  task automatic dump(string tag);
    for (int r = 0; r < 32; r++) do_rd(r, 3, 0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) refb[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, all registers zero
    dump("R1 reset");

    // R2 / R7: fill the file with vector elements of each width, from base 0
    for (int w = 0; w < 4; w++) begin
      for (int k = 0; k < (256 >> w); k++) do_wr(0, w, k, 1'b1, pat(k + w * 300));
      dump("R2 layout");
    end

    // R2 / R7 / R8 / R3: exhaustive read sweep over base, width and index
    for (int w = 0; w < 4; w++) begin
      for (int r = 0; r < 32; r++) begin
        for (int k = 0; k < 256; k++) begin
          int a = first_byte(r, w, k, 1'b1);
          if (a >= 256)            do_rd(r, w, k, 1'b1, "R8 read beyond end");
          else if (k * (1 << w) >= 8) do_rd(r, w, k, 1'b1, "R7 read spill");
          else                     do_rd(r, w, k, 1'b1, "R2 read element");
        end
        do_rd(r, w, 37, 1'b0, "R3 scalar read ignores index");
      end
    end

    // R4: zero extension of narrow elements from an all-ones register
    do_wr(3, 3, 0, 1'b1, '1);
    do_rd(3, 0, 2, 1'b1, "R4 zero-extend 8");
    check("R4 value 8", rd_data, 64'hFF);
    do_rd(3, 1, 1, 1'b1, "R4 zero-extend 16");
    check("R4 value 16", rd_data, 64'hFFFF);
    do_rd(3, 2, 1, 1'b1, "R4 zero-extend 32");
    check("R4 value 32", rd_data, 64'hFFFF_FFFF);

    // R5 / R3: scalar write masks and clears upper bits, index ignored
    do_wr(4, 3, 0, 1'b1, '1);
    do_wr(4, 1, 9, 1'b0, 64'h1234_5678_9ABC_DEF0);
    do_rd(4, 3, 0, 1'b0, "R5 scalar write clears upper");
    check("R5 exact value", rd_data, 64'h0000_0000_0000_DEF0);
    do_rd(5, 3, 0, 1'b0, "R3 scalar write leaves neighbour");

    // R5 / R6 / R7 / R8: mixed writes, each followed by readback
    for (int i = 0; i < 600; i++) begin
      int r = (i * 7 + 3) % 32;
      int w = i % 4;
      int k = (i * 13) % 256;
      bit v = (i % 3) != 0;
      int a = first_byte(r, w, k, v);
      do_wr(r, w, k, v, pat(i + 2000));
      if (!v) begin
        do_rd(r, 3, 0, 1'b0, "R5 scalar store");
      end else if (a >= 256) begin
        do_rd(r, w, k, 1'b1, "R8 write beyond end dropped");
        do_rd(31, 3, 0, 1'b0, "R8 last register untouched");
      end else begin
        do_rd(a / 8, 3, 0, 1'b0, (k * (1 << w) >= 8) ? "R7 spill store" : "R6 lane store");
        if (a / 8 + 1 < 32) do_rd(a / 8 + 1, 3, 0, 1'b0, "R6 next register kept");
        if (a / 8 > 0)      do_rd(a / 8 - 1, 3, 0, 1'b0, "R6 previous register kept");
      end
    end
    dump("R6 file after mixed writes");

    // R9: enable low, nothing changes
    @(negedge clk);
    wr_reg = 5'd7; wr_width = 2'd3; wr_off = 8'd0; wr_vec = 1'b0;
    wr_data = 64'hDEAD_BEEF_0BAD_F00D; wr_en = 1'b0;
    @(posedge clk);
    do_rd(7, 3, 0, 1'b0, "R9 no write when disabled");

    // R10: same-cycle read sees old data, new data after the edge
    @(negedge clk);
    wr_reg = 5'd9; wr_width = 2'd2; wr_off = 8'd1; wr_vec = 1'b1;
    wr_data = 64'h0000_0000_CAFE_F00D; wr_en = 1'b1;
    rd_reg = 5'd9; rd_width = 2'd2; rd_off = 8'd1; rd_vec = 1'b1;
    #1;
    check("R10 read before edge is old", rd_data, model_rd(9, 2, 1, 1'b1));
    @(posedge clk);
    #1 wr_en = 1'b0;
    model_wr(9, 2, 1, 1'b1, 64'h0000_0000_CAFE_F00D);
    #0.5;
    check("R9 write applied at edge", rd_data, 64'h0000_0000_CAFE_F00D);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule